// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This unit decides whether a control-transfer instruction is taken and where control goes next. It holds a four-bit condition-code register (zero, carry, overflow, negative). The register loads the flags of every ALU operation and keeps its value on cycles with no ALU operation. A branch request supplies an operation code, a flag selector, the branch PC, an immediate and two register operands. One clock later the unit returns a taken flag, the next-PC value and, for jump-and-link, a return address.

Three condition styles sit side by side:
- A flag test checks one selected condition code, set or clear.
- A compare-and-branch compares two registers for equality or inequality without using the flags.
- A register test checks whether a general register, holding an earlier compare or set-less-than result, is zero or nonzero.

Unconditional jumps take either an absolute address from the immediate or an address from a register. Each kind of jump has a linking variant.

The unit has no multi-state sequencer. Its only state is the condition-code register and the one-cycle result register.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and all four condition codes are 0, so a flag-set test of any flag is not taken.
- R2: On a cycle with `alu_valid`=1 the condition codes load `alu_flags`. On a cycle with `alu_valid`=0 they keep their value. The bit positions are 0 zero, 1 carry, 2 overflow, 3 negative, and `br_flag_sel` uses the same numbering.
- R3: Op 0 (flag set) is taken when the selected flag is 1. Op 1 (flag clear) is taken when the selected flag is 0.
- R4: Op 2 is taken when `br_rs1` equals `br_rs2`. Op 3 is taken when they differ.
- R5: Op 4 is taken when `br_rs1` is nonzero. Op 5 is taken when `br_rs1` is zero.
- R6: For ops 0 to 5, a taken branch gives `res_target` = `br_pc` + `br_imm`, with the immediate read as two's complement and the sum wrapping at XLEN bits. A not-taken branch gives `res_target` = `br_pc` + INSN_BYTES.
- R7: Ops 6 and 8 are always taken with target `br_imm`. Ops 7 and 9 are always taken with target `br_rs1`.
- R8: Ops 8 and 9 raise `res_link_we` with `res_link` = `br_pc` + INSN_BYTES. All other ops leave `res_link_we` at 0.
- R9: A result appears exactly one cycle after a cycle with `br_valid`=1, and only then. Op codes 10 to 15 give a not-taken result with no link.
- R10: A branch issued on the same cycle as an ALU flag update evaluates the flags held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_valid | input | 1 | An ALU operation completes this cycle |
| alu_flags | input | 4 | Flags of that ALU operation (Z,C,V,N at bits 0..3) |
| br_valid | input | 1 | A control-transfer request is present |
| br_op | input | 4 | Operation code (0..9) |
| br_flag_sel | input | 2 | Flag index for ops 0 and 1 |
| br_pc | input | XLEN | PC of the control-transfer instruction |
| br_imm | input | XLEN | PC-relative offset, or absolute target for ops 6/8 |
| br_rs1 | input | XLEN | First register operand or register target |
| br_rs2 | input | XLEN | Second register operand |
| res_valid | output | 1 | Result is valid this cycle |
| res_taken | output | 1 | Control transfer taken |
| res_target | output | XLEN | Next PC |
| res_link_we | output | 1 | Return address should be written |
| res_link | output | XLEN | Return address |

## Verification
The bench builds the unit with XLEN=16 and INSN_BYTES=2. With this narrow width, a negative offset that wraps below address zero and a sequential step that wraps past 0xFFFE are easy to write and to check by hand. The short step also makes the not-taken target visibly different from a four-byte step. Back-to-back requests with an interleaved ALU update exercise the rule that a same-cycle flag load is not seen.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int NFLAGS     = 4;
    localparam int FLAG_SEL_W = $clog2(NFLAGS);
    localparam int FLAG_Z     = 0;
    localparam int FLAG_C     = 1;
    localparam int FLAG_V     = 2;
    localparam int FLAG_N     = 3;

    typedef enum logic [3:0] {
        OP_FSET = 4'd0,
        OP_FCLR = 4'd1,
        OP_BEQ  = 4'd2,
        OP_BNE  = 4'd3,
        OP_BNZ  = 4'd4,
        OP_BZR  = 4'd5,
        OP_JABS = 4'd6,
        OP_JREG = 4'd7,
        OP_JALA = 4'd8,
        OP_JALR = 4'd9
    } br_op_e;

    typedef enum logic [1:0] {
        TGT_SEQ = 2'd0,
        TGT_REL = 2'd1,
        TGT_ABS = 2'd2,
        TGT_REG = 2'd3
    } tgt_sel_e;
endpackage

// File: rtl/bcu_flags.sv
module bcu_flags
    import bcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [NFLAGS-1:0] alu_flags,
    output logic [NFLAGS-1:0] flags
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (alu_valid)
                flags[i] <= alu_flags[i];
        end
    end

    // R2: flags follow the ALU only when an operation completes
    p_flag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |=> flags == $past(alu_flags));
    p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_valid |=> $stable(flags));
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
    import bcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]            op,
    input  logic [FLAG_SEL_W-1:0] flag_sel,
    input  logic [NFLAGS-1:0]     flags,
    input  logic [XLEN-1:0]       rs1,
    input  logic [XLEN-1:0]       rs2,
    output logic                  taken,
    output logic                  link,
    output tgt_sel_e              tgt_sel
);
    logic sel_flag;
    logic regs_eq;
    logic rs1_zero;

    assign sel_flag = flags[flag_sel];
    assign regs_eq  = (rs1 == rs2);
    assign rs1_zero = (rs1 == '0);

    always_comb begin
        taken   = 1'b0;
        link    = 1'b0;
        tgt_sel = TGT_SEQ;
        case (br_op_e'(op))
            OP_FSET: taken = sel_flag;
            OP_FCLR: taken = !sel_flag;
            OP_BEQ:  taken = regs_eq;
            OP_BNE:  taken = !regs_eq;
            OP_BNZ:  taken = !rs1_zero;
            OP_BZR:  taken = rs1_zero;
            OP_JABS: begin taken = 1'b1; tgt_sel = TGT_ABS; end
            OP_JREG: begin taken = 1'b1; tgt_sel = TGT_REG; end
            OP_JALA: begin taken = 1'b1; tgt_sel = TGT_ABS; link = 1'b1; end
            OP_JALR: begin taken = 1'b1; tgt_sel = TGT_REG; link = 1'b1; end
            default: taken = 1'b0;
        endcase
        if (taken && tgt_sel == TGT_SEQ)
            tgt_sel = TGT_REL;
    end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
    import bcu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  tgt_sel_e        tgt_sel,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] rs1,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] seq_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assign seq_pc = pc + STEP;

    always_comb begin
        unique case (tgt_sel)
            TGT_SEQ: next_pc = seq_pc;
            TGT_REL: next_pc = pc + imm;
            TGT_ABS: next_pc = imm;
            TGT_REG: next_pc = rs1;
        endcase
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bcu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alu_valid,
    input  logic [3:0]      alu_flags,
    input  logic            br_valid,
    input  logic [3:0]      br_op,
    input  logic [1:0]      br_flag_sel,
    input  logic [XLEN-1:0] br_pc,
    input  logic [XLEN-1:0] br_imm,
    input  logic [XLEN-1:0] br_rs1,
    input  logic [XLEN-1:0] br_rs2,
    output logic            res_valid,
    output logic            res_taken,
    output logic [XLEN-1:0] res_target,
    output logic            res_link_we,
    output logic [XLEN-1:0] res_link
);
    logic [NFLAGS-1:0] cc_q;
    logic              c_taken;
    logic              c_link;
    tgt_sel_e          c_tgt;
    logic [XLEN-1:0]   c_next;
    logic [XLEN-1:0]   c_seq;

    bcu_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_valid (alu_valid),
        .alu_flags (alu_flags),
        .flags     (cc_q)
    );

    bcu_cond #(.XLEN(XLEN)) u_cond (
        .op       (br_op),
        .flag_sel (br_flag_sel),
        .flags    (cc_q),
        .rs1      (br_rs1),
        .rs2      (br_rs2),
        .taken    (c_taken),
        .link     (c_link),
        .tgt_sel  (c_tgt)
    );

    bcu_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_target (
        .tgt_sel (c_tgt),
        .pc      (br_pc),
        .imm     (br_imm),
        .rs1     (br_rs1),
        .next_pc (c_next),
        .seq_pc  (c_seq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_link_we <= 1'b0;
            res_target  <= '0;
            res_link    <= '0;
        end else begin
            res_valid   <= br_valid;
            res_taken   <= br_valid && c_taken;
            res_link_we <= br_valid && c_link;
            if (br_valid) begin
                res_target <= c_next;
                res_link   <= c_seq;
            end
        end
    end

    // R9: one result per request, one cycle later
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !res_valid);
    p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid);
    // R7: every jump op resolves as taken
    p_jump_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_op >= 4'd6 && br_op <= 4'd9) |=> res_taken);
    // R8: a link write only accompanies a taken transfer
    p_link_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> (res_valid && res_taken));
    // R6: not-taken resolves to the sequential address
    p_seq_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> res_target == res_link);
endmodule

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
    localparam int W    = 16;
    localparam int STEP = 2;

    typedef struct {
        logic         taken;
        logic [W-1:0] target;
        logic         lwe;
        logic [W-1:0] link;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alu_valid = 1'b0;
    logic [3:0]   alu_flags = '0;
    logic         br_valid = 1'b0;
    logic [3:0]   br_op = '0;
    logic [1:0]   br_flag_sel = '0;
    logic [W-1:0] br_pc = '0, br_imm = '0, br_rs1 = '0, br_rs2 = '0;
    logic         res_valid, res_taken, res_link_we;
    logic [W-1:0] res_target, res_link;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    exp_t  sb[$];
    logic [3:0] m_flags = '0;

    always #2.5 clk = ~clk;

    branch_resolve_unit #(.XLEN(W), .INSN_BYTES(STEP)) u_branch_resolve_unit (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_flags(alu_flags),
        .br_valid(br_valid), .br_op(br_op), .br_flag_sel(br_flag_sel),
        .br_pc(br_pc), .br_imm(br_imm), .br_rs1(br_rs1), .br_rs2(br_rs2),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .res_link_we(res_link_we), .res_link(res_link)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one request per call, with an optional ALU flag load in the same cycle
    task automatic issue(input logic [3:0] op, input logic [1:0] sel, input logic [W-1:0] pc,
                         input logic [W-1:0] imm, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic av, input logic [3:0] af, input string req);
        exp_t e;
        logic f;
        @(negedge clk);
        br_valid = 1'b1; br_op = op; br_flag_sel = sel; br_pc = pc;
        br_imm = imm; br_rs1 = a; br_rs2 = b; alu_valid = av; alu_flags = af;
        f = m_flags[sel];
        e.taken = 1'b0; e.lwe = 1'b0; e.target = pc + W'(STEP);
        e.link = pc + W'(STEP); e.req = req;
        case (op)
            4'd0: e.taken = f;
            4'd1: e.taken = !f;
            4'd2: e.taken = (a == b);
            4'd3: e.taken = (a != b);
            4'd4: e.taken = (a != 0);
            4'd5: e.taken = (a == 0);
            default: ;
        endcase
        if (op <= 4'd5 && e.taken) e.target = pc + imm;
        if (op == 4'd6 || op == 4'd8) begin e.taken = 1'b1; e.target = imm; end
        if (op == 4'd7 || op == 4'd9) begin e.taken = 1'b1; e.target = a; end
        if (op == 4'd8 || op == 4'd9) e.lwe = 1'b1;
        sb.push_back(e);
        if (av) m_flags = af;
    endtask

    task automatic idle(input logic av, input logic [3:0] af);
        @(negedge clk);
        br_valid = 1'b0; alu_valid = av; alu_flags = af;
        if (av) m_flags = af;
    endtask

    // monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && !done && res_valid) begin
            if (sb.size() == 0) begin
                check("R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " taken"},  32'(res_taken),   32'(e.taken));
                check({e.req, " target"}, 32'(res_target),  32'(e.target));
                check({e.req, " linkwe"}, 32'(res_link_we), 32'(e.lwe));
                if (e.lwe) check({e.req, " link"}, 32'(res_link), 32'(e.link));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 res_valid in reset", 32'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res_valid after reset", 32'(res_valid), 0);
        // R1: all flags zero after reset
        issue(0, 0, 16'h0100, 16'h0020, 0, 0, 0, 0, "R1 fset Z");
        issue(0, 3, 16'h0100, 16'h0020, 0, 0, 0, 0, "R1 fset N");
        idle(1, 4'b0010);                          // R2: load carry
        idle(0, 4'b1101);                          // R2: masked, no load
        issue(0, 1, 16'h0200, 16'h0010, 0, 0, 0, 0, "R3 fset C");
        issue(1, 1, 16'h0200, 16'h0010, 0, 0, 0, 0, "R3 fclr C");
        issue(1, 0, 16'h0200, 16'h0010, 0, 0, 0, 0, "R2 masked fclr Z");
        // R10: update with branch in same cycle, then after
        issue(0, 1, 16'h0300, 16'h0040, 0, 0, 1, 4'b1000, "R10 old flags");
        issue(0, 1, 16'h0300, 16'h0040, 0, 0, 0, 0, "R10 new flags C");
        issue(0, 3, 16'h0300, 16'h0040, 0, 0, 0, 0, "R10 new flags N");
        issue(2, 0, 16'h0400, 16'h0008, 16'h1234, 16'h1234, 0, 0, "R4 beq eq");
        issue(2, 0, 16'h0400, 16'h0008, 16'h1234, 16'h1235, 0, 0, "R4 beq ne");
        issue(3, 0, 16'h0400, 16'h0008, 16'h1234, 16'h1235, 0, 0, "R4 bne ne");
        issue(3, 0, 16'h0400, 16'h0008, 16'hBEEF, 16'hBEEF, 0, 0, "R4 bne eq");
        issue(4, 0, 16'h0500, 16'h0030, 16'h0001, 0, 0, 0, "R5 bnz one");
        issue(4, 0, 16'h0500, 16'h0030, 16'h0000, 0, 0, 0, "R5 bnz zero");
        issue(5, 0, 16'h0500, 16'h0030, 16'h0000, 0, 0, 0, "R5 bzr zero");
        issue(5, 0, 16'h0500, 16'h0030, 16'h8000, 0, 0, 0, "R5 bzr msb");
        issue(2, 0, 16'h0010, 16'hFFE0, 5, 5, 0, 0, "R6 negative wrap");
        issue(3, 0, 16'hFFFE, 16'h0004, 5, 5, 0, 0, "R6 seq wrap");
        issue(6, 0, 16'h0600, 16'h4444, 16'h2222, 0, 0, 0, "R7 jabs");
        issue(7, 0, 16'h0600, 16'h4444, 16'h2222, 0, 0, 0, "R7 jreg");
        issue(8, 0, 16'h0700, 16'h5550, 16'h3330, 0, 0, 0, "R8 jal abs");
        issue(9, 0, 16'hFFFE, 16'h5550, 16'h3330, 0, 0, 0, "R8 jal reg wrap");
        issue(12, 2, 16'h0800, 16'h0100, 16'h0000, 0, 0, 0, "R9 undefined op");
        idle(0, 0);
        idle(0, 0);
        @(negedge clk);
        check("R9 no result when idle", 32'(res_valid), 0);
        check("R9 scoreboard drained", 32'(sb.size()), 0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule